// File: doc/BRIEF.md
# Open-Page DRAM Command Sequencer

This block sits between a cache-line request stream and a DDR-style DRAM device. Each request names a bank, a row and a column, and says whether it reads or writes. The block turns the request into the shortest legal series of device commands. Rows stay open after an access, and auto-precharge is never used. A request to the row that is already open in its bank needs only the column command. A request to a closed bank needs an activate first. A request to a different row of an open bank needs a precharge, then an activate, then the column command.

Before each command, the block waits until every timing gap that applies has run out. It issues the command on the first rising edge at which the command is legal. Every access is a burst of four beats, which takes two clock cycles on the data bus. Only one request is in flight at a time.

The request side is a valid/ready stream. `req_ready` is high whenever no request is held. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. The upstream side must hold its fields stable while `req_valid` is high and `req_ready` is low. `req_ready` stays low from acceptance until the edge that issues the request's column command. The command output has no back-pressure: one command, or a no-operation, is presented every cycle.

Top module: `dseq_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1 and `cmd_code` is the no-operation code.
- R2: Command codes are NOP=0, ACTIVATE=1, READ=2, WRITE=3, PRECHARGE=4. An activate drives the row on `cmd_addr`. A read or write drives the column on `cmd_addr[9:0]` with `cmd_addr[12:10]` zero, so bit 10 (auto-precharge) is always low. A precharge drives `cmd_addr` as zero, which selects a single bank. `cmd_bank` carries the request's bank on every command.
- R3: A request to a bank with no open row produces ACTIVATE and then the column command. The column command comes exactly 3 cycles after the activate, and an activate is never sent to a bank whose row is open.
- R4: A request to the open row of its bank produces only the column command. When no gap is pending, that command appears in the cycle right after the accepting edge.
- R5: A request to another row of an open bank produces PRECHARGE, then ACTIVATE 3 cycles later, then the column command 3 cycles after that.
- R6: Consecutive reads, or consecutive writes, to open rows are spaced exactly 2 cycles apart, so the data bus has no idle cycle between them.
- R7: After a WRITE, a READ to any bank waits at least 4 cycles, and a PRECHARGE to the same bank waits at least 5 cycles. Each is sent exactly then when nothing else holds it back.
- R8: After a READ, a WRITE waits at least 5 cycles, and a PRECHARGE to the same bank waits at least 2 cycles. Each is sent exactly then when nothing else holds it back.
- R9: A PRECHARGE comes at least 6 cycles after the ACTIVATE of its bank. Two ACTIVATEs to one bank are at least 9 cycles apart.
- R10: At most one command is issued per cycle. A cycle with no command carries the no-operation code with bank and address zero. `req_ready` is low exactly while a request's commands are still outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands change on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request stream valid |
| req_ready | output | 1 | Request stream ready; high when no request is held |
| req_write | input | 1 | 1 = write line, 0 = read line |
| req_bank | input | 2 | Bank of the request |
| req_row | input | 13 | Row of the request |
| req_col | input | 10 | Starting column of the burst |
| cmd_code | output | 3 | Device command code (see R2) |
| cmd_bank | output | 2 | Bank the command is aimed at |
| cmd_addr | output | 13 | Row, column or zero, depending on the command |

## Verification
The first command of a request is due one cycle after the accepting edge when no gap is pending. Each later command is due on the exact cycle its last gap expires: 3 cycles after an activate, 2 between same-direction bursts, 4 from write to read, 5 from read to write and from write to precharge. The bench samples outputs on the falling edge and numbers each rising edge. It logs the edge index of every command against an expected command queue that it builds at acceptance from its own open-row model. Directed chains compare exact edge differences, and every command in random traffic is checked against the minimum gaps.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } dram_cmd_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dseq_gate.sv
// Saturating down-counter that holds back one class of command.
// A load keeps the larger of the remaining wait and the new one.
module dseq_gate #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         open_o
);

  logic [W-1:0] cnt;
  logic [W-1:0] dec;
  logic [W-1:0] nxt;

  always_comb begin
    dec = (cnt == '0) ? '0 : cnt - 1'b1;
    nxt = (load && (load_val > dec)) ? load_val : dec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= nxt;
  end

  assign open_o = (cnt == '0);

  AST_GATE_LOAD_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != '0) |=> !open_o); // R9

endmodule

// File: rtl/dseq_row_table.sv
// Per-bank record of the open row.
module dseq_row_table
  import dseq_pkg::*;
#(
  parameter int BANKS  = 4,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [BANK_W-1:0] upd_bank,
  input  logic [ROW_W-1:0]  upd_row,
  input  logic [BANK_W-1:0] lk_bank,
  input  logic [ROW_W-1:0]  lk_row,
  output logic              lk_open,
  output logic              lk_hit
);

  logic [BANKS-1:0]            open_q;
  logic [BANKS-1:0][ROW_W-1:0] row_q;

  for (genvar b = 0; b < BANKS; b++) begin : g_entry
    logic hit_b;
    assign hit_b = (upd_bank == BANK_W'(b));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_q[b] <= 1'b0;
        row_q[b]  <= '0;
      end else if (hit_b && set_en) begin
        open_q[b] <= 1'b1;
        row_q[b]  <= upd_row;
      end else if (hit_b && clr_en) begin
        open_q[b] <= 1'b0;
      end
    end
  end

  assign lk_open = open_q[lk_bank];
  assign lk_hit  = open_q[lk_bank] && (row_q[lk_bank] == lk_row);

  AST_ACT_ON_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !open_q[upd_bank]); // R3
  AST_PRE_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> open_q[upd_bank]); // R5

endmodule

// File: rtl/dseq_timing.sv
// All inter-command gaps, as per-bank and bus-wide countdown gates.
module dseq_timing
  import dseq_pkg::*;
#(
  parameter int BANKS     = 4,
  parameter int BANK_W    = 2,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RAS     = 6,
  parameter int T_WR      = 2,
  parameter int T_WTR     = 1,
  parameter int T_CL      = 3,
  parameter int T_DQSS    = 1,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dram_cmd_e         iss_code,
  input  logic [BANK_W-1:0] iss_bank,
  output logic [BANKS-1:0]  act_ok,
  output logic [BANKS-1:0]  col_ok,
  output logic [BANKS-1:0]  pre_ok,
  output logic              rd_ok,
  output logic              wr_ok
);

  localparam int BURST_CYC = BURST_LEN / 2;
  localparam int T_RC      = T_RAS + T_RP;
  localparam int RD2WR     = T_CL + BURST_CYC;
  localparam int WR2RD     = T_DQSS + BURST_CYC + T_WTR;
  localparam int WR2PRE    = T_DQSS + BURST_CYC + T_WR;
  localparam int RD2PRE    = BURST_CYC;
  localparam int MAX_GAP   = max2(max2(max2(T_RC, RD2WR), max2(WR2RD, WR2PRE)),
                                  max2(max2(T_RCD, T_RP), max2(T_RAS, RD2PRE)));
  localparam int CNT_W     = $clog2(MAX_GAP + 1);

  localparam logic [CNT_W-1:0] L_RC     = CNT_W'(T_RC - 1);
  localparam logic [CNT_W-1:0] L_RP     = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] L_RCD    = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] L_RAS    = CNT_W'(T_RAS - 1);
  localparam logic [CNT_W-1:0] L_RD2PRE = CNT_W'(RD2PRE - 1);
  localparam logic [CNT_W-1:0] L_WR2PRE = CNT_W'(WR2PRE - 1);
  localparam logic [CNT_W-1:0] L_BURST  = CNT_W'(BURST_CYC - 1);
  localparam logic [CNT_W-1:0] L_WR2RD  = CNT_W'(WR2RD - 1);
  localparam logic [CNT_W-1:0] L_RD2WR  = CNT_W'(RD2WR - 1);

  logic is_act, is_pre, is_rd, is_wr;
  assign is_act = (iss_code == CMD_ACT);
  assign is_pre = (iss_code == CMD_PRE);
  assign is_rd  = (iss_code == CMD_RD);
  assign is_wr  = (iss_code == CMD_WR);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic             sel;
    logic             act_ld, col_ld, pre_ld;
    logic [CNT_W-1:0] act_v, pre_v;

    assign sel    = (iss_bank == BANK_W'(b));
    assign act_ld = sel && (is_act || is_pre);
    assign act_v  = is_act ? L_RC : L_RP;
    assign col_ld = sel && is_act;
    assign pre_ld = sel && (is_act || is_rd || is_wr);
    assign pre_v  = is_act ? L_RAS : (is_rd ? L_RD2PRE : L_WR2PRE);

    dseq_gate #(.W(CNT_W)) u_act_gate (
      .clk(clk), .rst_n(rst_n), .load(act_ld), .load_val(act_v), .open_o(act_ok[b]));
    dseq_gate #(.W(CNT_W)) u_col_gate (
      .clk(clk), .rst_n(rst_n), .load(col_ld), .load_val(L_RCD), .open_o(col_ok[b]));
    dseq_gate #(.W(CNT_W)) u_pre_gate (
      .clk(clk), .rst_n(rst_n), .load(pre_ld), .load_val(pre_v), .open_o(pre_ok[b]));
  end

  logic             bus_ld;
  logic [CNT_W-1:0] rd_v, wr_v;
  assign bus_ld = is_rd || is_wr;
  assign rd_v   = is_rd ? L_BURST : L_WR2RD;
  assign wr_v   = is_wr ? L_BURST : L_RD2WR;

  dseq_gate #(.W(CNT_W)) u_rd_gate (
    .clk(clk), .rst_n(rst_n), .load(bus_ld), .load_val(rd_v), .open_o(rd_ok));
  dseq_gate #(.W(CNT_W)) u_wr_gate (
    .clk(clk), .rst_n(rst_n), .load(bus_ld), .load_val(wr_v), .open_o(wr_ok));

  AST_WR_BLOCKS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    is_wr |=> !rd_ok); // R7
  AST_RD_BLOCKS_WR: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |=> !wr_ok); // R8

endmodule

// File: rtl/dseq_sequencer.sv
// Open-page command sequencer: one request in flight, greedy issue.
module dseq_sequencer
  import dseq_pkg::*;
#(
  parameter int BANKS     = 4,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int ADDR_W    = 13,
  parameter int AP_BIT    = 10,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RAS     = 6,
  parameter int T_WR      = 2,
  parameter int T_WTR     = 1,
  parameter int T_CL      = 3,
  parameter int T_DQSS    = 1,
  parameter int BURST_LEN = 4,
  localparam int BANK_W   = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic [2:0]        cmd_code,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr
);

  // Held request
  logic              pend;
  logic              p_write;
  logic [BANK_W-1:0] p_bank;
  logic [ROW_W-1:0]  p_row;
  logic [COL_W-1:0]  p_col;

  logic lk_open, lk_hit;
  logic [BANKS-1:0] act_ok, col_ok, pre_ok;
  logic rd_ok, wr_ok;

  dram_cmd_e         want;
  logic              ok;
  logic              issue;
  logic              accept;
  dram_cmd_e         nxt_code;
  logic [BANK_W-1:0] nxt_bank;
  logic [ADDR_W-1:0] nxt_addr;
  logic              col_issue;

  dram_cmd_e         code_q;
  logic [BANK_W-1:0] bank_q;
  logic [ADDR_W-1:0] addr_q;

  // Next command needed by the held request
  always_comb begin
    if (!lk_open)    want = CMD_ACT;
    else if (lk_hit) want = p_write ? CMD_WR : CMD_RD;
    else             want = CMD_PRE;
  end

  always_comb begin
    case (want)
      CMD_ACT: ok = act_ok[p_bank];
      CMD_PRE: ok = pre_ok[p_bank];
      CMD_RD:  ok = col_ok[p_bank] && rd_ok;
      CMD_WR:  ok = col_ok[p_bank] && wr_ok;
      default: ok = 1'b0;
    endcase
  end

  assign issue     = pend && ok;
  assign col_issue = issue && (want == CMD_RD || want == CMD_WR);
  assign accept    = req_valid && !pend;
  assign req_ready = !pend;

  always_comb begin
    nxt_code = CMD_NOP;
    nxt_bank = '0;
    nxt_addr = '0;
    if (issue) begin
      nxt_code = want;
      nxt_bank = p_bank;
      case (want)
        CMD_ACT: nxt_addr = ADDR_W'(p_row);
        CMD_RD, CMD_WR: begin
          nxt_addr         = ADDR_W'(p_col);
          nxt_addr[AP_BIT] = 1'b0;
        end
        default: nxt_addr = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      p_write <= 1'b0;
      p_bank  <= '0;
      p_row   <= '0;
      p_col   <= '0;
    end else if (accept) begin
      pend    <= 1'b1;
      p_write <= req_write;
      p_bank  <= req_bank;
      p_row   <= req_row;
      p_col   <= req_col;
    end else if (col_issue) begin
      pend    <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= CMD_NOP;
      bank_q <= '0;
      addr_q <= '0;
    end else begin
      code_q <= nxt_code;
      bank_q <= nxt_bank;
      addr_q <= nxt_addr;
    end
  end

  assign cmd_code = code_q;
  assign cmd_bank = bank_q;
  assign cmd_addr = addr_q;

  dseq_row_table #(.BANKS(BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_rows (
    .clk(clk), .rst_n(rst_n),
    .set_en(issue && want == CMD_ACT),
    .clr_en(issue && want == CMD_PRE),
    .upd_bank(p_bank), .upd_row(p_row),
    .lk_bank(p_bank), .lk_row(p_row),
    .lk_open(lk_open), .lk_hit(lk_hit));

  dseq_timing #(
    .BANKS(BANKS), .BANK_W(BANK_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS),
    .T_WR(T_WR), .T_WTR(T_WTR), .T_CL(T_CL), .T_DQSS(T_DQSS), .BURST_LEN(BURST_LEN)
  ) u_timing (
    .clk(clk), .rst_n(rst_n),
    .iss_code(nxt_code), .iss_bank(nxt_bank),
    .act_ok(act_ok), .col_ok(col_ok), .pre_ok(pre_ok),
    .rd_ok(rd_ok), .wr_ok(wr_ok));

  AST_AP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_RD || cmd_code == CMD_WR) |-> cmd_addr[AP_BIT] == 1'b0); // R2
  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_NOP) |-> (cmd_bank == '0 && cmd_addr == '0)); // R10
  AST_SINGLE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R10
  AST_RCD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_ACT) |=>
      !((cmd_code == CMD_RD || cmd_code == CMD_WR) && cmd_bank == $past(cmd_bank))); // R3
  AST_BURST_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_RD || cmd_code == CMD_WR) |=>
      !(cmd_code == CMD_RD || cmd_code == CMD_WR)); // R6
  AST_RP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_PRE) |=> !(cmd_code == CMD_ACT && cmd_bank == $past(cmd_bank))); // R5

endmodule

// File: tb/test_dseq_sequencer.sv
module test_dseq_sequencer;

  localparam int C_NOP = 0, C_ACT = 1, C_RD = 2, C_WR = 3, C_PRE = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_bank = '0;
  logic [12:0] req_row = '0;
  logic [9:0]  req_col = '0;
  logic [2:0]  cmd_code;
  logic [1:0]  cmd_bank;
  logic [12:0] cmd_addr;

  always #10 clk = ~clk;

  dseq_sequencer i_dseq_sequencer (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nvec = 0, nfail = 0;
  bit done = 0;

  task automatic chk(input bit good, input string tag, input int act, input int exp);
    nvec++;
    if (!good) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected command queue and open-row model
  int q_code[256], q_bank[256], q_addr[256];
  int qw = 0, qr = 0;
  bit m_open[4];
  int m_row[4];
  int acc_cyc = 0;

  task automatic push(input int c, input int b, input int a);
    q_code[qw % 256] = c; q_bank[qw % 256] = b; q_addr[qw % 256] = a; qw++;
  endtask

  // history and last-issue stamps
  int col_t[2048], act_t[2048], pre_t[2048];
  int n_col = 0, n_act = 0, n_pre = 0;
  int l_act[4], l_pre[4], l_rd[4], l_wr[4];
  int l_rd_any = -1000, l_wr_any = -1000;
  bit mon_en = 0;

  initial for (int i = 0; i < 4; i++) begin
    l_act[i] = -1000; l_pre[i] = -1000; l_rd[i] = -1000; l_wr[i] = -1000;
    m_open[i] = 0; m_row[i] = 0;
  end

  always @(negedge clk) begin
    int c, b, a, ec;
    string tg;
    if (mon_en) begin
      c = int'(cmd_code); b = int'(cmd_bank); a = int'(cmd_addr);
      if (c != C_NOP) begin
        if (qr == qw) chk(0, "R10 command with nothing outstanding", c, C_NOP);
        else begin
          ec = q_code[qr % 256];
          tg = (ec == C_ACT) ? "R3 command order" : (ec == C_PRE) ? "R5 command order" : "R4 command order";
          chk(c == ec, tg, c, ec);
          chk(b == q_bank[qr % 256], "R2 bank field", b, q_bank[qr % 256]);
          chk(a == q_addr[qr % 256], "R2 address field", a, q_addr[qr % 256]);
          qr++;
        end
        case (c)
          C_ACT: begin
            chk(cyc - l_pre[b] >= 3, "R5 PRE to ACT gap", cyc - l_pre[b], 3);
            chk(cyc - l_act[b] >= 9, "R9 ACT to ACT gap", cyc - l_act[b], 9);
            l_act[b] = cyc; act_t[n_act % 2048] = cyc; n_act++;
          end
          C_RD: begin
            chk(cyc - l_act[b] >= 3, "R3 ACT to READ gap", cyc - l_act[b], 3);
            chk(cyc - l_wr_any >= 4, "R7 WRITE to READ gap", cyc - l_wr_any, 4);
            chk(cyc - l_rd_any >= 2, "R6 READ to READ gap", cyc - l_rd_any, 2);
            l_rd[b] = cyc; l_rd_any = cyc; col_t[n_col % 2048] = cyc; n_col++;
          end
          C_WR: begin
            chk(cyc - l_act[b] >= 3, "R3 ACT to WRITE gap", cyc - l_act[b], 3);
            chk(cyc - l_rd_any >= 5, "R8 READ to WRITE gap", cyc - l_rd_any, 5);
            chk(cyc - l_wr_any >= 2, "R6 WRITE to WRITE gap", cyc - l_wr_any, 2);
            l_wr[b] = cyc; l_wr_any = cyc; col_t[n_col % 2048] = cyc; n_col++;
          end
          C_PRE: begin
            chk(cyc - l_act[b] >= 6, "R9 ACT to PRE gap", cyc - l_act[b], 6);
            chk(cyc - l_wr[b] >= 5, "R7 WRITE to PRE gap", cyc - l_wr[b], 5);
            chk(cyc - l_rd[b] >= 2, "R8 READ to PRE gap", cyc - l_rd[b], 2);
            l_pre[b] = cyc; pre_t[n_pre % 2048] = cyc; n_pre++;
          end
          default: chk(0, "R2 illegal command code", c, C_NOP);
        endcase
      end else begin
        chk(b == 0 && a == 0, "R10 idle cycle fields", b * 8192 + a, 0);
      end
      chk(req_ready == (qr == qw), "R10 ready while outstanding", int'(req_ready), int'(qr == qw));
    end
  end

  task automatic send(input bit w, input int b, input int r, input int c);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_bank = 2'(b); req_row = 13'(r); req_col = 10'(c);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    acc_cyc = cyc;
    if (!m_open[b]) push(C_ACT, b, r);
    else if (m_row[b] != r) begin push(C_PRE, b, 0); push(C_ACT, b, r); end
    push(w ? C_WR : C_RD, b, c);
    m_open[b] = 1; m_row[b] = r;
  endtask

  task automatic wait_idle(input int n);
    while (qr != qw) @(negedge clk);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  initial begin
    int a0, c0, p0, acc2;
    void'($urandom(32'h1d5e_0bad));
    repeat (3) @(negedge clk);
    chk(cmd_code == 3'd0, "R1 NOP during reset", int'(cmd_code), 0);
    chk(req_ready == 1'b1, "R1 ready during reset", int'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_code == 3'd0, "R1 NOP after reset", int'(cmd_code), 0);
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    mon_en = 1;

    // chain: idle write, write hit, read hit, read hit, write hit, read miss
    a0 = n_act; c0 = n_col; p0 = n_pre;
    send(1, 0, 5, 8);  acc2 = acc_cyc;
    send(1, 0, 5, 12);
    send(0, 0, 5, 16);
    send(0, 0, 5, 20);
    send(1, 0, 5, 24);
    send(0, 0, 9, 28);
    wait_idle(2);
    chk(act_t[a0] == acc2 + 1, "R4 first command one cycle after accept", act_t[a0], acc2 + 1);
    chk(col_t[c0] - act_t[a0] == 3, "R3 ACT to WRITE exact", col_t[c0] - act_t[a0], 3);
    chk(col_t[c0+1] - col_t[c0] == 2, "R6 WRITE to WRITE exact", col_t[c0+1] - col_t[c0], 2);
    chk(col_t[c0+2] - col_t[c0+1] == 4, "R7 WRITE to READ exact", col_t[c0+2] - col_t[c0+1], 4);
    chk(col_t[c0+3] - col_t[c0+2] == 2, "R6 READ to READ exact", col_t[c0+3] - col_t[c0+2], 2);
    chk(col_t[c0+4] - col_t[c0+3] == 5, "R8 READ to WRITE exact", col_t[c0+4] - col_t[c0+3], 5);
    chk(pre_t[p0] - col_t[c0+4] == 5, "R7 WRITE to PRE exact", pre_t[p0] - col_t[c0+4], 5);
    chk(act_t[a0+1] - pre_t[p0] == 3, "R5 PRE to ACT exact", act_t[a0+1] - pre_t[p0], 3);
    chk(col_t[c0+5] - act_t[a0+1] == 3, "R5 ACT to READ exact", col_t[c0+5] - act_t[a0+1], 3);

    // row must stay open 6 cycles before precharge
    wait_idle(20);
    a0 = n_act; p0 = n_pre;
    send(0, 1, 2, 40);
    send(0, 1, 3, 44);
    wait_idle(2);
    chk(pre_t[p0] - act_t[a0] == 6, "R9 ACT to PRE exact", pre_t[p0] - act_t[a0], 6);

    // hit latency and read to precharge
    wait_idle(20);
    send(0, 2, 1, 50);
    wait_idle(20);
    c0 = n_col; p0 = n_pre;
    send(0, 2, 1, 52);  acc2 = acc_cyc;
    send(0, 2, 4, 56);
    wait_idle(2);
    chk(col_t[c0] == acc2 + 1, "R4 hit issued one cycle after accept", col_t[c0], acc2 + 1);
    chk(pre_t[p0] - col_t[c0] == 2, "R8 READ to PRE exact", pre_t[p0] - col_t[c0], 2);

    // constrained random traffic
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 3 == 0) repeat ($urandom % 5) @(negedge clk);
      send(1'($urandom % 2), int'($urandom % 4), int'($urandom % 3), int'($urandom % 1024));
    end
    wait_idle(20);
    chk(qr == qw, "R10 all requests completed", qr, qw);

    done = 1;
    summary();
    $finish;
  end

endmodule